// File: doc/BRIEF.md
# GPIO Pad Community Controller

This block controls one community of general-purpose pads, arranged as a small number of banks with the same pad count in each. Each pad owns a two-word configuration record in a memory-mapped array. The first word drives the pad output and selects how the pad's input is turned into events: no event, a level, a rising edge or any edge, with an optional inversion applied first. The first word also shows the pad's synchronised input level. The second word is general storage.

Events are latched into one sticky status word per bank. Software clears these bits by writing a one to them. Each bank also has an enable word, and a single interrupt line goes high whenever any latched status bit is enabled. Software finds the start of the configuration array by reading a pointer register at a fixed offset.

The host uses a plain 32-bit bus. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. A read is requested the same way with `bus_wr` low, and its data appears on `bus_rdata` after that clock edge. `bus_rdata` then holds its value until the next read.

Top module: `gpio_pad_comm`

## Requirements
- R1: A read of offset 0x00C returns the byte offset of the pad record array (parameter PAD_BASE, default 0x400). Writes to 0x00C are ignored.
- R2: Pad p's word 0 is at PAD_BASE+16*p and its word 1 is at PAD_BASE+16*p+4. Word 1 stores and returns all 32 bits. Offsets +8 and +12 of a record read zero.
- R3: Bit 0 of pad p's word 0 drives pad_out[p] from the edge at which it is written.
- R4: Bit 1 of word 0 ignores writes and reads the pad input after a two-flop synchroniser.
- R5: Bits 31:30 (reset-config), 26:25 (event type) and 23 (inversion) of word 0 read back as written. Every other bit of word 0, apart from bits 0 and 1, reads zero.
- R6: With event type 00 (level), the pad's status bit is set on every cycle in which the conditioned input is high. The conditioned input is the synchronised input XOR bit 23.
- R7: With event type 01, only a 0-to-1 change of the conditioned input sets the status bit.
- R8: With event type 11, any change of the conditioned input sets the status bit. Event type 10 never sets it.
- R9: The status word of bank b is at 0x100+4*b, with bit n for pad n of the bank. Writing a 1 to a bit clears it and writing 0 leaves it unchanged. An event in the same cycle as its clear leaves the bit set.
- R10: The enable word of bank b is at 0x120+4*b. irq is high exactly when some status bit and its enable bit are both set.
- R11: Status and enable bits at or above the bank's pad count (BANK_PADS) read zero and ignore writes.
- R12: After reset, every record, status word and enable word reads zero, pad_out is all zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | NUM_BANKS*BANK_PADS | Raw pad input levels |
| pad_out | output | NUM_BANKS*BANK_PADS | Pad output drive levels |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the host issues at most one access per cycle and uses word-aligned addresses. They also assume that pad inputs are defined (not X) at every sampling edge, even though these inputs may change at any time relative to the clock. The stimulus keeps to these assumptions:
- Bus signals are driven only at falling edges, one access at a time.
- Pad inputs always hold 0 or 1.
- Random traffic uses only mapped offsets and a few unmapped ones.

// File: rtl/gpio_comm_pkg.sv
package gpio_comm_pkg;

  typedef enum logic [1:0] {
    EV_LEVEL = 2'b00,
    EV_RISE  = 2'b01,
    EV_OFF   = 2'b10,
    EV_ANY   = 2'b11
  } ev_mode_e;

  localparam int PTR_OFFS   = 'h00C;
  localparam int STAT_OFFS  = 'h100;
  localparam int EN_OFFS    = 'h120;
  localparam int REC_STRIDE = 16;

  // word 0 field positions
  localparam int TX_BIT  = 0;
  localparam int RX_BIT  = 1;
  localparam int INV_BIT = 23;
  localparam int MODE_LO = 25;
  localparam int RC_LO   = 30;

  function automatic logic pad_event(ev_mode_e m, logic cur, logic prev);
    case (m)
      EV_LEVEL: return cur;
      EV_RISE:  return cur & ~prev;
      EV_ANY:   return cur ^ prev;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic int rec_addr(int base, int pad, int word);
    return base + REC_STRIDE * pad + 4 * word;
  endfunction

  function automatic int bank_addr(int offs, int bank);
    return offs + 4 * bank;
  endfunction

endpackage

// File: rtl/gpio_pad_front.sv
module gpio_pad_front
  import gpio_comm_pkg::*;
#(
  parameter int NP = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NP-1:0]   pad_in,
  input  logic [NP-1:0]   inv_vec,
  input  logic [2*NP-1:0] mode_vec,
  output logic [NP-1:0]   sync_vec,
  output logic [NP-1:0]   evt_vec
);

  logic [NP-1:0] meta_q;
  logic [NP-1:0] sync_q;
  logic [NP-1:0] prev_q;
  logic [NP-1:0] cond;

  assign cond = sync_q ^ inv_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      prev_q <= cond;
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_evt
    assign evt_vec[p] = pad_event(ev_mode_e'(mode_vec[2*p +: 2]), cond[p], prev_q[p]);
  end

  assign sync_vec = sync_q;

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_comm_pkg::*;
#(
  parameter int NP       = 48,
  parameter int ADDR_W   = 12,
  parameter int PAD_BASE = 'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [NP-1:0]     sync_vec,
  output logic [NP-1:0]     tx_vec,
  output logic [NP-1:0]     inv_vec,
  output logic [2*NP-1:0]   mode_vec,
  output logic [31:0]       rd_word
);

  logic [31:0] pad_rd [NP];

  for (genvar p = 0; p < NP; p++) begin : g_pad
    localparam logic [ADDR_W-1:0] A_W0 = ADDR_W'(rec_addr(PAD_BASE, p, 0));
    localparam logic [ADDR_W-1:0] A_W1 = ADDR_W'(rec_addr(PAD_BASE, p, 1));

    logic        tx_q, inv_q;
    logic [1:0]  mode_q, rc_q;
    logic [31:0] w1_q;
    logic [31:0] w0_view;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tx_q   <= 1'b0;
        inv_q  <= 1'b0;
        mode_q <= 2'b00;
        rc_q   <= 2'b00;
        w1_q   <= '0;
      end else if (wr_en) begin
        if (addr == A_W0) begin
          tx_q   <= wdata[TX_BIT];
          inv_q  <= wdata[INV_BIT];
          mode_q <= wdata[MODE_LO +: 2];
          rc_q   <= wdata[RC_LO +: 2];
        end
        if (addr == A_W1) w1_q <= wdata;
      end
    end

    always_comb begin
      w0_view = '0;
      w0_view[TX_BIT]       = tx_q;
      w0_view[RX_BIT]       = sync_vec[p];
      w0_view[INV_BIT]      = inv_q;
      w0_view[MODE_LO +: 2] = mode_q;
      w0_view[RC_LO +: 2]   = rc_q;
    end

    assign pad_rd[p] = (addr == A_W0) ? w0_view :
                       (addr == A_W1) ? w1_q : 32'h0;
    assign tx_vec[p]         = tx_q;
    assign inv_vec[p]        = inv_q;
    assign mode_vec[2*p +: 2] = mode_q;
  end

  always_comb begin
    rd_word = '0;
    for (int p = 0; p < NP; p++) rd_word = rd_word | pad_rd[p];
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_comm_pkg::*;
#(
  parameter int NB     = 2,
  parameter int BP     = 24,
  parameter int ADDR_W = 12,
  localparam int NP    = NB * BP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [NP-1:0]     evt_vec,
  output logic [NP-1:0]     stat_vec,
  output logic [NP-1:0]     en_vec,
  output logic [NP-1:0]     clr_vec,
  output logic [31:0]       rd_word,
  output logic              irq
);

  logic [31:0] bank_rd [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(bank_addr(STAT_OFFS, b));
    localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(bank_addr(EN_OFFS, b));

    logic [BP-1:0] stat_q, en_q;

    assign clr_vec[b*BP +: BP] = (wr_en && addr == A_ST) ? wdata[BP-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_q <= '0;
        en_q   <= '0;
      end else begin
        stat_q <= (stat_q & ~clr_vec[b*BP +: BP]) | evt_vec[b*BP +: BP];
        if (wr_en && addr == A_EN) en_q <= wdata[BP-1:0];
      end
    end

    assign bank_rd[b] = (addr == A_ST) ? 32'(stat_q) :
                        (addr == A_EN) ? 32'(en_q) : 32'h0;
    assign stat_vec[b*BP +: BP] = stat_q;
    assign en_vec[b*BP +: BP]   = en_q;
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NB; b++) rd_word = rd_word | bank_rd[b];
  end

  assign irq = |(stat_vec & en_vec);

endmodule

// File: rtl/gpio_pad_comm.sv
module gpio_pad_comm
  import gpio_comm_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_PADS = 24,
  parameter int ADDR_W    = 12,
  parameter int PAD_BASE  = 'h400,
  localparam int NP       = NUM_BANKS * BANK_PADS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NP-1:0]     pad_in,
  output logic [NP-1:0]     pad_out,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_PTR = ADDR_W'(PTR_OFFS);

  logic            wr_en, rd_en;
  logic [NP-1:0]   sync_vec, evt_vec, inv_vec, tx_vec;
  logic [2*NP-1:0] mode_vec;
  logic [NP-1:0]   stat_vec, en_vec, clr_vec;
  logic [31:0]     cfg_rd, irq_rd, rd_next;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  gpio_pad_front #(.NP(NP)) u_front (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .inv_vec(inv_vec),
    .mode_vec(mode_vec), .sync_vec(sync_vec), .evt_vec(evt_vec)
  );

  gpio_cfg_regs #(.NP(NP), .ADDR_W(ADDR_W), .PAD_BASE(PAD_BASE)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr), .wdata(bus_wdata),
    .sync_vec(sync_vec), .tx_vec(tx_vec), .inv_vec(inv_vec),
    .mode_vec(mode_vec), .rd_word(cfg_rd)
  );

  gpio_irq_bank #(.NB(NUM_BANKS), .BP(BANK_PADS), .ADDR_W(ADDR_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr), .wdata(bus_wdata),
    .evt_vec(evt_vec), .stat_vec(stat_vec), .en_vec(en_vec), .clr_vec(clr_vec),
    .rd_word(irq_rd), .irq(irq)
  );

  assign rd_next = (bus_addr == A_PTR) ? 32'(PAD_BASE) : (cfg_rd | irq_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_next;
  end

  assign pad_out = tx_vec;

endmodule

// File: rtl/gpio_pad_comm_chk.sv
module gpio_pad_comm_chk #(
  parameter int NP = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [NP-1:0]   evt_vec,
  input logic [NP-1:0]   clr_vec,
  input logic [NP-1:0]   stat_vec,
  input logic [NP-1:0]   en_vec,
  input logic [2*NP-1:0] mode_vec,
  input logic [NP-1:0]   pad_out,
  input logic            irq
);

  assert_evt_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec != '0) |=> ((stat_vec & $past(evt_vec)) == $past(evt_vec)));

  assert_only_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (($past(stat_vec) & ~stat_vec & ~$past(clr_vec)) == '0));

  assert_set_needs_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat_vec & ~$past(stat_vec) & ~$past(evt_vec)) == '0));

  assert_irq_needs_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((stat_vec & en_vec) != '0));

  assert_tx_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_sel && bus_wr) |-> $stable(pad_out));

  for (genvar p = 0; p < NP; p++) begin : g_off
    assert_mode_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_vec[2*p +: 2] == 2'b10) |-> !evt_vec[p]);
  end

endmodule

bind gpio_pad_comm gpio_pad_comm_chk #(.NP(NP)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .evt_vec(evt_vec), .clr_vec(clr_vec), .stat_vec(stat_vec), .en_vec(en_vec),
  .mode_vec(mode_vec), .pad_out(pad_out), .irq(irq)
);

// File: tb/tb_gpio_pad_comm.sv
`timescale 1ns/1ps
module tb_gpio_pad_comm;
  localparam int NB = 2, BP = 24, NP = NB * BP, PB = 'h400;
  localparam logic [31:0] PMASK = (32'h1 << BP) - 1;

  logic clk = 0, rst_n = 0, bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [NP-1:0] pad_in = '0;
  wire  [31:0] bus_rdata;
  wire  [NP-1:0] pad_out;
  wire  irq;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  gpio_pad_comm dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .irq(irq)
  );

  // behavioural reference
  logic [NP-1:0] m_s1, m_s2, m_prev, m_tx, m_inv;
  logic [1:0]    m_mode [NP];
  logic [1:0]    m_rc   [NP];
  logic [31:0]   m_w1   [NP];
  logic [31:0]   m_stat [NB];
  logic [31:0]   m_en   [NB];
  logic [31:0]   m_rdata;

  function automatic logic [31:0] m_read(int a);
    logic [31:0] w;
    if (a == 'h00C) return PB;
    for (int b = 0; b < NB; b++) begin
      if (a == 'h100 + 4*b) return m_stat[b];
      if (a == 'h120 + 4*b) return m_en[b];
    end
    if (a >= PB && a < PB + 16*NP) begin
      int p, off;
      p = (a - PB) / 16;
      off = (a - PB) % 16;
      if (off == 4) return m_w1[p];
      if (off == 0) begin
        w = '0;
        w[0] = m_tx[p]; w[1] = m_s2[p]; w[23] = m_inv[p];
        w[26:25] = m_mode[p]; w[31:30] = m_rc[p];
        return w;
      end
    end
    return 32'h0;
  endfunction

  always @(posedge clk) begin : model
    logic [NP-1:0] ev;
    logic c;
    int ai;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_tx = '0; m_inv = '0; m_rdata = '0;
      for (int p = 0; p < NP; p++) begin m_mode[p] = 0; m_rc[p] = 0; m_w1[p] = 0; end
      for (int b = 0; b < NB; b++) begin m_stat[b] = 0; m_en[b] = 0; end
    end else begin
      if (bus_sel && !bus_wr) m_rdata = m_read(int'(bus_addr));
      for (int p = 0; p < NP; p++) begin
        c = m_s2[p] ^ m_inv[p];
        case (m_mode[p])
          2'b00:   ev[p] = c;
          2'b01:   ev[p] = c && !m_prev[p];
          2'b11:   ev[p] = (c != m_prev[p]);
          default: ev[p] = 1'b0;
        endcase
        m_prev[p] = c; m_s2[p] = m_s1[p]; m_s1[p] = pad_in[p];
      end
      if (bus_sel && bus_wr) begin
        ai = int'(bus_addr);
        for (int b = 0; b < NB; b++) begin
          if (ai == 'h100 + 4*b) m_stat[b] = m_stat[b] & ~bus_wdata;
          if (ai == 'h120 + 4*b) m_en[b] = bus_wdata & PMASK;
        end
        if (ai >= PB && ai < PB + 16*NP) begin
          int p;
          p = (ai - PB) / 16;
          if ((ai - PB) % 16 == 0) begin
            m_tx[p] = bus_wdata[0]; m_inv[p] = bus_wdata[23];
            m_mode[p] = bus_wdata[26:25]; m_rc[p] = bus_wdata[31:30];
          end
          if ((ai - PB) % 16 == 4) m_w1[p] = bus_wdata;
        end
      end
      for (int b = 0; b < NB; b++) m_stat[b] = m_stat[b] | 32'(ev[b*BP +: BP]);
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic e_irq;
      e_irq = 1'b0;
      for (int b = 0; b < NB; b++) e_irq = e_irq | (|(m_stat[b] & m_en[b]));
      chk("R10 irq vs model", 64'(irq), 64'(e_irq));
      chk("R3 pad_out vs model", 64'(pad_out), 64'(m_tx));
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 12'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(int a, string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 12'(a);
    @(negedge clk);
    bus_sel = 0;
    chk(tag, 64'(bus_rdata), 64'(m_rdata));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // R12 reset state
    chk("R12 irq after reset", 64'(irq), 64'(0));
    chk("R12 pad_out after reset", 64'(pad_out), 64'(0));
    rd('h100, "R12 status0 reset");  chk("R12 status0 literal", 64'(bus_rdata), 64'(0));
    rd('h124, "R12 enable1 reset");
    rd('h400, "R12 pad0 w0 reset");  chk("R12 w0 literal", 64'(bus_rdata), 64'(0));
    // R1 pointer
    rd('h00C, "R1 pointer");         chk("R1 pointer literal", 64'(bus_rdata), 64'h400);
    wr('h00C, 32'h0);
    rd('h00C, "R1 pointer after write"); chk("R1 ro literal", 64'(bus_rdata), 64'h400);
    // R6 level, R9 event wins over clear
    wr('h120, 32'h1);
    pad_in[0] = 1; idle(4);
    rd('h100, "R6 level status");    chk("R6 level literal", 64'(bus_rdata), 64'h1);
    wr('h100, 32'h1);
    rd('h100, "R9 event beats clear"); chk("R9 set persists", 64'(bus_rdata), 64'h1);
    pad_in[0] = 0; idle(4);
    wr('h100, 32'h1);
    rd('h100, "R9 cleared");         chk("R9 cleared literal", 64'(bus_rdata), 64'h0);
    // R6 inversion on pad1
    wr('h410, 32'h0080_0000); idle(3);
    rd('h100, "R6 inverted level");  chk("R6 inv literal", 64'(bus_rdata[1]), 64'h1);
    wr('h410, 32'h0480_0000);        // inverted, event type off
    wr('h100, 32'hFFFF_FFFF);
    rd('h100, "R8 off mode quiet");  chk("R8 off literal", 64'(bus_rdata), 64'h0);
    // R7 rising edge on pad2
    wr('h420, 32'h0200_0000);
    pad_in[2] = 1; idle(4);
    rd('h100, "R7 rise");            chk("R7 rise literal", 64'(bus_rdata), 64'h4);
    wr('h100, 32'h4);
    pad_in[2] = 0; idle(4);
    rd('h100, "R7 fall ignored");    chk("R7 fall literal", 64'(bus_rdata), 64'h0);
    // R8 both edges on pad3, type 10 on pad30
    wr('h430, 32'h0600_0000);
    pad_in[3] = 1; idle(4);
    rd('h100, "R8 both rise");       chk("R8 rise literal", 64'(bus_rdata), 64'h8);
    wr('h100, 32'h8);
    pad_in[3] = 0; idle(4);
    rd('h100, "R8 both fall");       chk("R8 fall literal", 64'(bus_rdata), 64'h8);
    // R9 writing zero has no effect
    wr('h100, 32'h0);
    rd('h100, "R9 zero write");      chk("R9 zero literal", 64'(bus_rdata), 64'h8);
    wr('h100, 32'h8);
    wr('h5E0, 32'h0400_0000);
    pad_in[30] = 1; idle(4); pad_in[30] = 0; idle(4);
    rd('h104, "R8 type10 silent");   chk("R8 type10 literal", 64'(bus_rdata), 64'h0);
    // R11 unused bits
    wr('h124, 32'hFFFF_FFFF);
    rd('h124, "R11 enable width");   chk("R11 enable literal", 64'(bus_rdata), 64'h00FF_FFFF);
    pad_in[47] = 1; idle(4);
    rd('h104, "R11 status width");   chk("R11 status literal", 64'(bus_rdata), 64'h0080_0000);
    chk("R10 irq high", 64'(irq), 64'h1);
    pad_in[47] = 0; idle(3);
    wr('h104, 32'hFFFF_FFFF); idle(1);
    chk("R10 irq low", 64'(irq), 64'h0);
    // R5, R3, R2 on pad5
    wr('h450, 32'hFFFF_FFFF);
    rd('h450, "R5 w0 fields");       chk("R5 w0 literal", 64'(bus_rdata), 64'hC680_0001);
    chk("R3 pad_out bit5", 64'(pad_out[5]), 64'h1);
    wr('h454, 32'hA5A5_1234);
    rd('h454, "R2 word1");           chk("R2 w1 literal", 64'(bus_rdata), 64'hA5A5_1234);
    rd('h458, "R2 reserved word");   chk("R2 reserved literal", 64'(bus_rdata), 64'h0);
    wr('h450, 32'h0);
    chk("R3 pad_out cleared", 64'(pad_out[5]), 64'h0);
    // R4 input view
    pad_in[7] = 1;
    rd('h470, "R4 sync lag");
    idle(3);
    rd('h470, "R4 input bit");       chk("R4 rx literal", 64'(bus_rdata[1]), 64'h1);
    wr('h470, 32'h0000_0002);
    rd('h470, "R4 write ignored");   chk("R4 ro literal", 64'(bus_rdata[1:0]), 64'h2);
    // random traffic, compared to the model
    for (int i = 0; i < 1500; i++) begin
      int sel, p;
      sel = $urandom % 6;
      p = $urandom % NP;
      case (sel)
        0: pad_in[p] = ~pad_in[p];
        1: wr(PB + 16*p, $urandom);
        2: wr('h100 + 4*($urandom % NB), $urandom);
        3: wr('h120 + 4*($urandom % NB), $urandom);
        4: rd(PB + 16*p + 4*($urandom % 4), "R2 random record read");
        default: rd('h100 + 4*($urandom % 12), "R9 random status read");
      endcase
    end
    idle(2);
    finish_run();
  end

endmodule